// File: doc/BRIEF.md
# Memory Clock Power-Down Divider Controller

This block drives the memory clock pin of a clock generator. While the part runs normally it forwards the synthesized memory clock. When the active-low power-down pin is pulled low, one of two standby behaviours is taken, chosen by a mode bit that is read at the moment of entry. In the refresh mode the output is first parked high for a short, fixed number of reference cycles. It then toggles at the reference frequency divided by an even divisor, so that dynamic memory keeps being refreshed. In the shut mode the output is stopped low and its driver is released.

The whole block runs on the reference clock. The synthesized memory clock arrives as a data input sampled in that domain, and every output is registered. The divisor comes from a 4-bit code: codes 1 to 15 give a divisor of 34 minus twice the code, so the range runs from 32 down to 4. Code 0 falls back to the default divisor of 18, which is also what code 8 selects. An output-enable input gates the pin driver independently of everything else.

The controller is a four-state machine. NORMAL forwards the memory clock. PARK holds the pin high. DIVIDE produces the divided clock. SHUT holds the pin quiet. Its transitions:
- NORMAL to PARK: power-down is asserted with the mode bit at 0.
- NORMAL to SHUT: power-down is asserted with the mode bit at 1.
- PARK to DIVIDE: the park count expires.
- PARK, DIVIDE or SHUT to NORMAL: the power-down pin is released.

Top module: `mclk_pd_ctrl`

## Requirements
- R1: While reset is asserted, `mclk_o` and `mclk_drive` are both 0, and after reset the block starts in NORMAL.
- R2: `mclk_drive` one cycle after an edge equals `out_en` sampled at that edge, except in shut mode, where it is 0.
- R3: In NORMAL, `mclk_o` after an edge equals `mclk_syn` sampled at that edge.
- R4: When `pd_n` is sampled low from NORMAL with `pd_mode`=0, `mclk_o` is 1 after that edge and stays 1 for PARK_LEN (default 2) cycles in total.
- R5: After the park, `mclk_o` is a clock that starts low and whose high and low phases each last divisor/2 reference cycles. For codes 1 to 15 of the 4-bit `div_code`, the divisor is 34-2*code (code 15 gives 4, code 1 gives 32).
- R6: `div_code`=0 gives a divisor of 18, with phases of 9 cycles.
- R7: Every entry into the refresh mode restarts with the full park and a full first low phase, whatever the phase was at the last exit.
- R8: When `pd_n` is sampled low from NORMAL with `pd_mode`=1, both `mclk_o` and `mclk_drive` are 0 after that edge and stay 0 while `pd_n` stays low.
- R9: `pd_mode` is read only on entry to power-down. Changing it while `pd_n` stays low changes neither `mclk_o` nor `mclk_drive`.
- R10: When `pd_n` is sampled high in any power-down state, the block is in NORMAL after that edge and forwards `mclk_syn` as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; every register uses it |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclk_syn | input | 1 | Synthesized memory clock, sampled as data |
| out_en | input | 1 | Output enable; low releases the pin driver |
| pd_n | input | 1 | Power-down request, active low |
| pd_mode | input | 1 | 0 = refresh divider, 1 = shut all outputs |
| div_code | input | 4 | Power-down divisor code |
| mclk_o | output | 1 | Memory clock output value |
| mclk_drive | output | 1 | Pin driver enable; 0 means tristate |

## Verification
The divided clock is exercised with three codes: the shortest divisor (code 15), the longest (code 1), and the default reached through both code 8 and code 0. Using these codes separates an error in the decode slope from an error in the fallback and from an off-by-one in the phase length. Power-down is entered with each mode, the mode bit is flipped while power-down is held, and the request is released in the middle of a phase and then asserted again. These steps tell a counter that restarts apart from one that resumes, and a mode that is latched at entry apart from one that is followed live. An output-enable pulse during normal forwarding checks that the driver gate is independent of the clock path.

// File: rtl/mpd_pkg.sv
package mpd_pkg;

    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_PARK   = 2'd1,
        ST_DIVIDE = 2'd2,
        ST_SHUT   = 2'd3
    } mpd_state_t;

endpackage

// File: rtl/mpd_half_decode.sv
module mpd_half_decode #(
    parameter int CODE_W   = 4,
    parameter int DIV_BASE = 34,
    parameter int DEF_CODE = 8,
    parameter int CNT_W    = 5
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  half
);
    // The divisor is DIV_BASE - 2*code, so half a period is DIV_BASE/2 - code.
    localparam int HALF_BASE = DIV_BASE / 2;
    localparam int DEF_HALF  = HALF_BASE - DEF_CODE;

    always_comb begin
        if (code == '0) begin
            half = CNT_W'(DEF_HALF);
        end else begin
            half = CNT_W'(HALF_BASE) - CNT_W'(code);
        end
    end
endmodule

// File: rtl/mpd_phase_counter.sv
module mpd_phase_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;

    assign tick = run && (cnt >= (limit - CNT_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run) begin
            if (tick) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // The count advances by one on each running cycle that does not end a phase.
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear && !tick) |=> (cnt == $past(cnt) + CNT_W'(1))); // R5

    // After the last cycle of a phase the count starts again from zero.
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick || clear) |=> (cnt == '0)); // R7
endmodule

// File: rtl/mpd_seq.sv
module mpd_seq
    import mpd_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int PARK_LEN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mclk_syn,
    input  logic             out_en,
    input  logic             pd_n,
    input  logic             pd_mode,
    input  logic [CNT_W-1:0] half,
    input  logic             tick,
    output logic             cnt_clear,
    output logic             cnt_run,
    output logic [CNT_W-1:0] cnt_limit,
    output logic             mclk_q,
    output logic             drive_q
);
    mpd_state_t state, nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_NORMAL;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_NORMAL: if (!pd_n) nxt = pd_mode ? ST_SHUT : ST_PARK;
            ST_PARK: begin
                if (pd_n) begin
                    nxt = ST_NORMAL;
                end else if (tick) begin
                    nxt = ST_DIVIDE;
                end
            end
            ST_DIVIDE: if (pd_n) nxt = ST_NORMAL;
            ST_SHUT:   if (pd_n) nxt = ST_NORMAL;
        endcase
    end

    assign cnt_clear = (state != nxt);
    assign cnt_run   = (state == ST_PARK) || (state == ST_DIVIDE);
    assign cnt_limit = (state == ST_PARK) ? CNT_W'(PARK_LEN) : half;

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mclk_q  <= 1'b0;
            drive_q <= 1'b0;
        end else begin
            drive_q <= out_en && (nxt != ST_SHUT);
            unique case (nxt)
                ST_NORMAL: mclk_q <= mclk_syn;
                ST_PARK:   mclk_q <= 1'b1;
                ST_DIVIDE: begin
                    if (state != ST_DIVIDE) begin
                        mclk_q <= 1'b0;
                    end else if (tick) begin
                        mclk_q <= ~mclk_q;
                    end
                end
                ST_SHUT:   mclk_q <= 1'b0;
            endcase
        end
    end

    AST_PARK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORMAL && !pd_n && !pd_mode) |=> mclk_q); // R4

    AST_SHUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORMAL && !pd_n && pd_mode) |=> (!mclk_q && !drive_q)); // R8

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DIVIDE && !pd_n && !tick) |=> $stable(mclk_q)); // R5

    AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> !drive_q); // R2

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_NORMAL && pd_n) |=> (state == ST_NORMAL)); // R10
endmodule

// File: rtl/mclk_pd_ctrl.sv
module mclk_pd_ctrl #(
    parameter int CODE_W   = 4,
    parameter int DIV_BASE = 34,
    parameter int DEF_CODE = 8,
    parameter int PARK_LEN = 2
) (
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic              mclk_syn,
    input  logic              out_en,
    input  logic              pd_n,
    input  logic              pd_mode,
    input  logic [CODE_W-1:0] div_code,
    output logic              mclk_o,
    output logic              mclk_drive
);
    localparam int HALF_MAX = DIV_BASE / 2 - 1;
    localparam int LIM_MAX  = (HALF_MAX > PARK_LEN) ? HALF_MAX : PARK_LEN;
    localparam int CNT_W    = $clog2(LIM_MAX + 1);

    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] cnt_limit;
    logic             cnt_clear;
    logic             cnt_run;
    logic             tick;

    mpd_half_decode #(
        .CODE_W  (CODE_W),
        .DIV_BASE(DIV_BASE),
        .DEF_CODE(DEF_CODE),
        .CNT_W   (CNT_W)
    ) u_decode (
        .code(div_code),
        .half(half)
    );

    mpd_phase_counter #(
        .CNT_W(CNT_W)
    ) u_counter (
        .clk  (ref_clk),
        .rst_n(rst_n),
        .clear(cnt_clear),
        .run  (cnt_run),
        .limit(cnt_limit),
        .tick (tick)
    );

    mpd_seq #(
        .CNT_W   (CNT_W),
        .PARK_LEN(PARK_LEN)
    ) u_seq (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .mclk_syn (mclk_syn),
        .out_en   (out_en),
        .pd_n     (pd_n),
        .pd_mode  (pd_mode),
        .half     (half),
        .tick     (tick),
        .cnt_clear(cnt_clear),
        .cnt_run  (cnt_run),
        .cnt_limit(cnt_limit),
        .mclk_q   (mclk_o),
        .drive_q  (mclk_drive)
    );

    // While released from power-down with the driver enabled, the pin forwards the input.
    AST_PASS_THRU: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (pd_n && $past(pd_n) && $past(pd_n, 2)) |=> (mclk_o == $past(mclk_syn))); // R3

    AST_DRIVE_RESET: assert property (@(posedge ref_clk)
        !rst_n |-> (!mclk_drive && !mclk_o)); // R1
endmodule

// File: tb/tb_mclk_pd_ctrl.sv
module tb_mclk_pd_ctrl;
    localparam int PARK = 2;

    logic       ref_clk = 1'b0;
    logic       rst_n   = 1'b0;
    logic       mclk_syn = 1'b0;
    logic       out_en  = 1'b0;
    logic       pd_n    = 1'b1;
    logic       pd_mode = 1'b0;
    logic [3:0] div_code = 4'd8;
    logic       mclk_o;
    logic       mclk_drive;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    bit    exp_clk_q[$];
    bit    exp_drv_q[$];
    string tag_q[$];

    // Requirement model state
    int m_mode = 0;   // 0 normal, 1 refresh, 2 shut
    int m_t    = 0;
    int m_half = 9;

    always #2.5 ref_clk = ~ref_clk;

    mclk_pd_ctrl dut (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .mclk_syn  (mclk_syn),
        .out_en    (out_en),
        .pd_n      (pd_n),
        .pd_mode   (pd_mode),
        .div_code  (div_code),
        .mclk_o    (mclk_o),
        .mclk_drive(mclk_drive)
    );

    // Driver: apply one input vector at a falling edge and queue what must follow the next rising edge.
    task automatic apply(input bit rst, input bit oe, input bit pd, input bit md,
                         input logic [3:0] code, input bit mi, input string force_tag);
        bit    ec, ed;
        string tg;
        @(negedge ref_clk);
        rst_n    = !rst;
        out_en   = oe;
        pd_n     = pd;
        pd_mode  = md;
        div_code = code;
        mclk_syn = mi;
        if (rst) begin
            m_mode = 0;
            ec = 1'b0; ed = 1'b0; tg = "R1";
        end else begin
            if (pd) begin
                m_mode = 0;
            end else if (m_mode == 0) begin
                m_mode = md ? 2 : 1;
                m_t    = 0;
                m_half = (code == 4'd0) ? 9 : 17 - int'(code);
            end else begin
                m_t++;
            end
            case (m_mode)
                0: begin ec = mi; tg = "R3"; end
                1: begin
                    if (m_t < PARK) begin
                        ec = 1'b1; tg = "R4";
                    end else begin
                        ec = (((m_t - PARK) / m_half) % 2) != 0;
                        tg = (code == 4'd0) ? "R6" : "R5";
                    end
                end
                default: begin ec = 1'b0; tg = "R8"; end
            endcase
            ed = oe && (m_mode != 2);
            if (!oe) tg = "R2";
        end
        if (force_tag != "") tg = force_tag;
        exp_clk_q.push_back(ec);
        exp_drv_q.push_back(ed);
        tag_q.push_back(tg);
    endtask

    task automatic run_cycles(input int n, input bit oe, input bit pd, input bit md,
                              input logic [3:0] code, input string tg);
        for (int i = 0; i < n; i++) begin
            apply(1'b0, oe, pd, md, code, ((i % 3) == 1) || ((i % 5) == 0), tg);
        end
    endtask

    // Monitor: compare after each rising edge, away from the edge.
    always @(posedge ref_clk) begin
        #1;
        if (exp_clk_q.size() > 0) begin
            bit    ec, ed;
            string tg;
            ec = exp_clk_q.pop_front();
            ed = exp_drv_q.pop_front();
            tg = tag_q.pop_front();
            vectors++;
            if (mclk_o !== ec || mclk_drive !== ed) begin
                fails++;
                $display("FAIL %s: mclk_o=%b drive=%b expected mclk_o=%b drive=%b at %0t",
                         tg, mclk_o, mclk_drive, ec, ed, $time);
            end
        end
    end

    initial begin
        // R1 reset state
        for (int i = 0; i < 3; i++) apply(1'b1, 1'b1, 1'b1, 1'b0, 4'd8, 1'b1, "R1");
        // R3 forwarding, R2 enable gate
        run_cycles(10, 1'b1, 1'b1, 1'b0, 4'd8, "");
        run_cycles(4, 1'b0, 1'b1, 1'b0, 4'd8, "R2");
        run_cycles(3, 1'b1, 1'b1, 1'b0, 4'd8, "R2");
        // R4/R5 refresh with default code 8
        run_cycles(42, 1'b1, 1'b0, 1'b0, 4'd8, "");
        // R10 release
        run_cycles(5, 1'b1, 1'b1, 1'b0, 4'd8, "R10");
        // R5 shortest divisor, code 15
        run_cycles(20, 1'b1, 1'b0, 1'b0, 4'd15, "");
        run_cycles(3, 1'b1, 1'b1, 1'b0, 4'd15, "R10");
        // R5 longest divisor, code 1
        run_cycles(70, 1'b1, 1'b0, 1'b0, 4'd1, "");
        run_cycles(3, 1'b1, 1'b1, 1'b0, 4'd1, "R10");
        // R6 code 0 fallback
        run_cycles(40, 1'b1, 1'b0, 1'b0, 4'd0, "");
        run_cycles(3, 1'b1, 1'b1, 1'b0, 4'd0, "R10");
        // R8 shut mode, then R9 mode bit flipped while held
        run_cycles(5, 1'b1, 1'b0, 1'b1, 4'd8, "R8");
        run_cycles(5, 1'b1, 1'b0, 1'b0, 4'd8, "R9");
        run_cycles(3, 1'b1, 1'b1, 1'b0, 4'd8, "R10");
        // R9 mode bit raised during refresh
        run_cycles(6, 1'b1, 1'b0, 1'b0, 4'd15, "");
        run_cycles(8, 1'b1, 1'b0, 1'b1, 4'd15, "R9");
        run_cycles(2, 1'b1, 1'b1, 1'b0, 4'd15, "R10");
        // R7 exit mid-phase, re-enter: full park and full first phase
        run_cycles(7, 1'b1, 1'b0, 1'b0, 4'd14, "");
        run_cycles(1, 1'b1, 1'b1, 1'b0, 4'd14, "R10");
        run_cycles(12, 1'b1, 1'b0, 1'b0, 4'd14, "R7");
        run_cycles(4, 1'b1, 1'b1, 1'b0, 4'd14, "R10");
        // drain
        repeat (3) @(posedge ref_clk);
        #2;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule